// File: doc/BRIEF.md
# Timer Control and Status Register Block

This block holds the two configuration words of a processor timer unit: a 32-bit control word that software loads whole, and a 32-bit status word whose flags are set by hardware event pulses and cleared by software. The decrementer, fixed-interval and watchdog counting logic sits outside. Those counters raise single-cycle set pulses into this block, and they read back the period, reset-control and auto-reload fields from the control word.

Each interrupt output is a level signal. It is high while a sticky status flag and its matching enable bit in the control word are both 1. Software writes 1s to the status word to acknowledge flags. A resume input drops the watchdog-related state in one step after the core returns from a halt, so that the watchdog does not expire at once.

Top module: `tmr_regs`

## Requirements
- R1: While rst_ni is low, the control word and the status word are 0 and all three interrupt outputs are 0.
- R2: A control write (wr_en_i=1, wr_sel_i=0) loads wr_data_i[31:22] into the control word on the next edge. Bits 21:0 read as 0. Fields: 31:30 watchdog period, 29:28 watchdog reset control, 27 watchdog irq enable, 26 decrementer irq enable, 25:24 fixed-interval period, 23 fixed-interval irq enable, 22 auto-reload.
- R3: A status write (wr_en_i=1, wr_sel_i=1) clears each status bit whose data bit is 1 and leaves every other status bit unchanged.
- R4: Set pulses make status flags sticky until they are cleared. dec_set_i sets bit 27, fit_set_i sets bit 26, wdg_int_set_i sets bit 30, wdg_arm_set_i sets bit 31, and wdg_rst_set_i[1:0] is ORed into bits 29:28. Bits 25:0 read as 0.
- R5: When a set pulse and a software clear or a resume clear hit the same status bit in the same cycle, the bit ends up 1.
- R6: dec_irq_o is 1 exactly while status bit 27 and control bit 26 are both 1.
- R7: fit_irq_o is 1 exactly while status bit 26 and control bit 23 are both 1.
- R8: wdg_irq_o is 1 exactly while status bit 30 and control bit 27 are both 1.
- R9: resume_i clears status bits 31:28 on the next edge and leaves bits 27:26 unchanged.
- R10: rd_data_o returns the control word when rd_sel_i=0 and the status word when rd_sel_i=1. It is combinational from the stored state.
- R11: A write to one word leaves the other word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control, 1 status |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 1 | Read source: 0 control, 1 status |
| rd_data_o | output | 32 | Read data |
| dec_set_i | input | 1 | Decrementer event pulse |
| fit_set_i | input | 1 | Fixed-interval event pulse |
| wdg_int_set_i | input | 1 | Watchdog interrupt event pulse |
| wdg_arm_set_i | input | 1 | Watchdog enable-next event pulse |
| wdg_rst_set_i | input | 2 | Watchdog reset status bits to OR in |
| resume_i | input | 1 | Run-resume pulse, clears watchdog state |
| dec_irq_o | output | 1 | Decrementer interrupt level |
| fit_irq_o | output | 1 | Fixed-interval interrupt level |
| wdg_irq_o | output | 1 | Watchdog interrupt level |

## Verification
On every cycle, the assertions check the interrupt gating against the stored words and check that unused bits stay 0. They also check the one-cycle effects of a control load, a write-one-to-clear, a resume and a set pulse that collides with a clear. What only the bench's scenarios show is the sticky behaviour across long idle runs, the independence of the two words under mixed writes, and the pseudo-random mixes in which sets, clears and resumes land together in many combinations.

// File: rtl/tmr_regs_pkg.sv
package tmr_regs_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned NIRQ = 3;

  // control word bit positions (read by the counters)
  localparam int unsigned C_WDG_IE = 27;
  localparam int unsigned C_DEC_IE = 26;
  localparam int unsigned C_FIT_IE = 23;

  // status word bit positions
  localparam int unsigned S_ENW    = 31;
  localparam int unsigned S_WIS    = 30;
  localparam int unsigned S_WRS_HI = 29;
  localparam int unsigned S_WRS_LO = 28;
  localparam int unsigned S_DIS    = 27;
  localparam int unsigned S_FIS    = 26;

  localparam logic [DW-1:0] CTRL_MASK = 32'hFFC0_0000;
  localparam logic [DW-1:0] STAT_MASK = 32'hFC00_0000;
  localparam logic [DW-1:0] WDG_MASK  = 32'hF000_0000;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} reg_sel_e;
endpackage

// File: rtl/tmr_ctrl_reg.sv
module tmr_ctrl_reg #(
  parameter int unsigned        DW   = 32,
  parameter logic [DW-1:0]      MASK = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= data_i & MASK;
  end
endmodule

// File: rtl/tmr_stat_reg.sv
module tmr_stat_reg #(
  parameter int unsigned   DW       = 32,
  parameter logic [DW-1:0] MASK     = '1,
  parameter logic [DW-1:0] RES_MASK = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] clr_i,
  input  logic          resume_i,
  input  logic [DW-1:0] set_i,
  output logic [DW-1:0] q_o
);
  logic [DW-1:0] res_clr, nxt;

  always_comb begin
    res_clr = resume_i ? RES_MASK : '0;
    // set is ORed last so it wins over both clears
    nxt     = ((q_o & ~clr_i & ~res_clr) | set_i) & MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/tmr_irq_gate.sv
module tmr_irq_gate #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] flag_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] irq_o
);
  for (genvar g = 0; g < N; g++) begin : g_ch
    assign irq_o[g] = flag_i[g] & en_i[g];
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_regs_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_sel_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_sel_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          dec_set_i,
  input  logic          fit_set_i,
  input  logic          wdg_int_set_i,
  input  logic          wdg_arm_set_i,
  input  logic [1:0]    wdg_rst_set_i,
  input  logic          resume_i,
  output logic          dec_irq_o,
  output logic          fit_irq_o,
  output logic          wdg_irq_o
);
  logic [DW-1:0]   ctrl_q, stat_q, set_vec, clr_vec;
  logic            ctrl_ld;
  logic [NIRQ-1:0] flags, enables, irqs;

  assign ctrl_ld = wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_CTRL);
  assign clr_vec = (wr_en_i && (reg_sel_e'(wr_sel_i) == SEL_STAT)) ? wr_data_i : '0;

  always_comb begin
    set_vec                    = '0;
    set_vec[S_DIS]             = dec_set_i;
    set_vec[S_FIS]             = fit_set_i;
    set_vec[S_WIS]             = wdg_int_set_i;
    set_vec[S_ENW]             = wdg_arm_set_i;
    set_vec[S_WRS_HI:S_WRS_LO] = wdg_rst_set_i;
  end

  tmr_ctrl_reg #(.DW(DW), .MASK(CTRL_MASK)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ctrl_ld),
    .data_i (wr_data_i),
    .q_o    (ctrl_q)
  );

  tmr_stat_reg #(.DW(DW), .MASK(STAT_MASK), .RES_MASK(WDG_MASK)) u_stat (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (clr_vec),
    .resume_i (resume_i),
    .set_i    (set_vec),
    .q_o      (stat_q)
  );

  // channel order: 0 decrementer, 1 fixed-interval, 2 watchdog
  assign flags   = {stat_q[S_WIS],    stat_q[S_FIS],    stat_q[S_DIS]};
  assign enables = {ctrl_q[C_WDG_IE], ctrl_q[C_FIT_IE], ctrl_q[C_DEC_IE]};

  tmr_irq_gate #(.N(NIRQ)) u_gate (
    .flag_i (flags),
    .en_i   (enables),
    .irq_o  (irqs)
  );

  assign dec_irq_o = irqs[0];
  assign fit_irq_o = irqs[1];
  assign wdg_irq_o = irqs[2];

  assign rd_data_o = (reg_sel_e'(rd_sel_i) == SEL_STAT) ? stat_q : ctrl_q;
endmodule

// File: rtl/tmr_regs_chk.sv
module tmr_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_en_i,
  input logic        wr_sel_i,
  input logic [31:0] wr_data_i,
  input logic        rd_sel_i,
  input logic [31:0] rd_data_o,
  input logic        dec_set_i,
  input logic        fit_set_i,
  input logic        wdg_int_set_i,
  input logic        wdg_arm_set_i,
  input logic [1:0]  wdg_rst_set_i,
  input logic        resume_i,
  input logic        dec_irq_o,
  input logic        fit_irq_o,
  input logic        wdg_irq_o,
  input logic [31:0] ctrl_q,
  input logic [31:0] stat_q
);
  logic any_set;
  assign any_set = dec_set_i | fit_set_i | wdg_int_set_i | wdg_arm_set_i | (|wdg_rst_set_i);

  a_r2_ctrl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i) |=> ctrl_q == ($past(wr_data_i) & 32'hFFC0_0000));

  a_r3_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && !any_set && !resume_i) |=> stat_q == ($past(stat_q) & ~$past(wr_data_i)));

  a_r4_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & 32'h03FF_FFFF) == 0) && ((ctrl_q & 32'h003F_FFFF) == 0));

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_int_set_i |=> stat_q[30]);

  a_r6_dec_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_irq_o == (stat_q[27] && ctrl_q[26]));

  a_r7_fit_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fit_irq_o == (stat_q[26] && ctrl_q[23]));

  a_r8_wdg_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_irq_o == (stat_q[30] && ctrl_q[27]));

  a_r9_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_i && !wdg_int_set_i && !wdg_arm_set_i && wdg_rst_set_i == 2'b00 && !(wr_en_i && wr_sel_i))
      |=> (stat_q[31:28] == 4'h0) && (stat_q[27:26] == ($past(stat_q[27:26]) | {$past(dec_set_i), $past(fit_set_i)})));

  a_r11_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && !wr_sel_i) |=> $stable(ctrl_q));
endmodule

bind tmr_regs tmr_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
  .dec_set_i(dec_set_i), .fit_set_i(fit_set_i), .wdg_int_set_i(wdg_int_set_i),
  .wdg_arm_set_i(wdg_arm_set_i), .wdg_rst_set_i(wdg_rst_set_i), .resume_i(resume_i),
  .dec_irq_o(dec_irq_o), .fit_irq_o(fit_irq_o), .wdg_irq_o(wdg_irq_o),
  .ctrl_q(ctrl_q), .stat_q(stat_q)
);

// File: tb/tmr_regs_tb.sv
`timescale 1ns/1ps
module tmr_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0, resume = 1'b0;
  logic [31:0] wr_data = '0, rd_data;
  logic        dec_set = 1'b0, fit_set = 1'b0, wint_set = 1'b0, warm_set = 1'b0;
  logic [1:0]  wrst_set = 2'b00;
  logic        dec_irq, fit_irq, wdg_irq;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  logic [31:0] m_ctrl = '0, m_stat = '0;

  always #2 clk = ~clk;

  tmr_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .dec_set_i(dec_set), .fit_set_i(fit_set), .wdg_int_set_i(wint_set),
    .wdg_arm_set_i(warm_set), .wdg_rst_set_i(wrst_set), .resume_i(resume),
    .dec_irq_o(dec_irq), .fit_irq_o(fit_irq), .wdg_irq_o(wdg_irq)
  );

  // behavioural reference, per requirement text
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_stat = 0;
    end else begin
      logic [31:0] s;
      s = m_stat;
      if (wr_en && wr_sel) s = s & ~wr_data;
      if (resume) s[31:28] = 4'h0;
      if (dec_set)  s[27] = 1'b1;
      if (fit_set)  s[26] = 1'b1;
      if (wint_set) s[30] = 1'b1;
      if (warm_set) s[31] = 1'b1;
      s[29:28] = s[29:28] | wrst_set;
      s[25:0] = '0;
      if (wr_en && !wr_sel) m_ctrl = {wr_data[31:22], 22'd0};
      m_stat = s;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    rd_sel = 1'b0; #0.2;
    chk({tag, " R10 ctrl read"}, rd_data, m_ctrl);
    rd_sel = 1'b1; #0.2;
    chk({tag, " R10 stat read"}, rd_data, m_stat);
    chk({tag, " R6 dec_irq"}, {31'd0, dec_irq}, {31'd0, m_stat[27] & m_ctrl[26]});
    chk({tag, " R7 fit_irq"}, {31'd0, fit_irq}, {31'd0, m_stat[26] & m_ctrl[23]});
    chk({tag, " R8 wdg_irq"}, {31'd0, wdg_irq}, {31'd0, m_stat[30] & m_ctrl[27]});
  endtask

  // sets: [0] dec [1] fit [2] wdg int [3] wdg arm [5:4] wdg reset status
  task automatic step(input string tag, input bit we, input bit ws, input logic [31:0] wd,
                      input bit res, input logic [5:0] sets);
    wr_en = we; wr_sel = ws; wr_data = wd; resume = res;
    dec_set = sets[0]; fit_set = sets[1]; wint_set = sets[2];
    warm_set = sets[3]; wrst_set = sets[5:4];
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; resume = 0; dec_set = 0; fit_set = 0; wint_set = 0; warm_set = 0; wrst_set = 0;
    compare(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    chk("R1 ctrl zero", m_ctrl, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 after reset");
    step("R2 ctrl all ones", 1, 0, 32'hFFFF_FFFF, 0, 6'b0);
    step("R11 stat write no ctrl effect", 1, 1, 32'hFFFF_FFFF, 0, 6'b0);
    step("R4 set dec", 0, 0, 0, 0, 6'b000001);
    step("R4 sticky", 0, 0, 0, 0, 6'b0);
    step("R4 set all", 0, 0, 0, 0, 6'b111111);
    step("R3 clear bit27 only", 1, 1, 32'h0800_0000, 0, 6'b0);
    step("R5 set beats clear", 1, 1, 32'h4400_0000, 0, 6'b000110);
    step("R9 resume", 0, 0, 0, 1, 6'b0);
    step("R4 refill", 0, 0, 0, 0, 6'b111111);
    step("R5 set beats resume", 0, 0, 0, 1, 6'b000100);
    step("R2 ctrl pattern", 1, 0, 32'h0880_0000, 0, 6'b0);
    step("R11 ctrl write keeps stat", 1, 0, 32'h5555_5555, 0, 6'b0);
    step("R3 clear all", 1, 1, 32'hFFFF_FFFF, 0, 6'b0);
    step("R7 fit only", 1, 0, 32'h0080_0000, 0, 6'b000010);
    for (int i = 0; i < 400; i++) begin
      logic [5:0]  s;
      logic [31:0] d;
      logic [3:0]  r;
      s = 6'($urandom) & 6'($urandom);
      d = $urandom;
      r = 4'($urandom);
      step("R5 random mix", r[0], r[1], d, r[2] & r[3], s);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule